// File: doc/BRIEF.md
# RC5-32 Key Expansion Step Pipeline

This block carries out a single mixing step of the RC5-32 key expansion as a fully pipelined datapath that accepts a new step every clock cycle. The step takes the running pair A and B, one word of the expanded S table and one word of the secret-key array L. It returns the refreshed A, which becomes the new S entry, and the refreshed B, which becomes the new L entry. A chain of these steps, with table storage and index sequencing supplied around them, performs the whole expansion.

To keep the logic depth of the data-dependent rotation small, the step applies only the low four bits of the rotation amount. The remaining half-word rotation is not performed. A one-bit command travels with the B result so that the next consumer can finish the rotation. The inputs B and L may arrive with the same kind of pending half-word rotation, and each is flagged by its own command bit. The step resolves these on entry.

Operands are staggered in time. A and S enter together, B follows one cycle later and L three cycles later. The S word, the raw L word and the raw L command pass through fixed delay lines, so that they line up with the needs of the next step in a chain.

Top module: `rc5_ksched_step`

## Requirements
- R1: When `b_cmd_in` is 1, the word on `b_in` is rotated left by 16 positions before any use; when it is 0, the word is used as given. The adjusted word is called B'.
- R2: `a_out` equals ROTL3(A + S + B') modulo 2^32. It appears 5 cycles after A and S are presented, where B' is taken from the cycle after A.
- R3: With t = A_new + B', where A_new is the R2 result, `b_out` equals t + L' rotated left by the amount in t[3:0] only. It appears 6 cycles after A is presented.
- R4: `b_cmd_out` equals bit 4 of t and is valid in the same cycle as the matching `b_out`.
- R5: When `l_cmd_in` is 1, the word on `l_in` is rotated left by 16 positions to form L'; when it is 0, L' equals `l_in`.
- R6: For one step, B and its command are presented one cycle after A and S. L and its command are presented three cycles after A and S.
- R7: `s_out` repeats `s_in` delayed by 3 cycles.
- R8: `l_out` repeats the unrotated `l_in` delayed by 12 cycles. `l_cmd_out` repeats `l_cmd_in` delayed by 14 cycles.
- R9: While `rst_n` is sampled low, every output is driven to zero on the following cycle.
- R10: A new step can start on every cycle. Each step's results depend only on its own operands, even when steps are issued back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| a_in | input | 32 | Running A value, presented in the step's first cycle |
| s_in | input | 32 | S table word, presented with A |
| b_in | input | 32 | Running B value, one cycle after A |
| b_cmd_in | input | 1 | 1 = rotate `b_in` left by 16 before use |
| l_in | input | 32 | Key array word, three cycles after A |
| l_cmd_in | input | 1 | 1 = rotate `l_in` left by 16 before use |
| a_out | output | 32 | New A / new S entry, 5 cycles after A |
| s_out | output | 32 | `s_in` delayed 3 cycles |
| b_out | output | 32 | New B / new L entry with the half-word rotation still pending, 6 cycles after A |
| b_cmd_out | output | 1 | Pending half-word rotation flag for `b_out` |
| l_out | output | 32 | Raw `l_in` delayed 12 cycles |
| l_cmd_out | output | 1 | `l_cmd_in` delayed 14 cycles |

## Verification
Because the A path is one stage shorter than the B path, the A result of one step and the B result of the step issued a cycle earlier leave the block in the same cycle. While that happens, the operands of later steps are already inside the pipeline. The bench provokes this overlap by issuing a table of steps on consecutive cycles, with each step's B and L staggered behind its A. It judges every output port on every cycle against an independent model of the partial-rotation rule, indexed by the step each output should belong to. A reset raised while the pipeline is full checks that no stale step leaks out afterwards.

// File: rtl/ks_pkg.sv
// Package: shared defaults for the key-expansion step pipeline.
// Assumes a 32-bit word and a rotation amount that is a power-of-two width.
package ks_pkg;
    parameter int KS_WORD_W   = 32;   // data word width
    parameter int KS_ROT_W    = 4;    // rotation amount bits applied inside the step
    parameter int KS_A_ROT    = 3;    // fixed rotation on the A path
    parameter int KS_S_DLY    = 3;    // S pass-through delay
    parameter int KS_L_DLY    = 12;   // L pass-through delay
    parameter int KS_LCMD_DLY = 14;   // L command pass-through delay

    // Register pair carried along the B side of the pipeline
    typedef struct packed {
        logic [KS_WORD_W-1:0] word;
        logic                 cmd;
    } ks_word_cmd_t;
endpackage

// File: rtl/ks_cmd_rot.sv
// Module: ks_cmd_rot
// Resolves a pending half-word rotation: rotates the input left by W/2
// when the command bit is set, passes it unchanged otherwise.
// Assumes W is even. Purely combinational.
module ks_cmd_rot #(
    parameter int W = 32
) (
    input  logic [W-1:0] din,
    input  logic         cmd,
    output logic [W-1:0] dout
);
    localparam int HALF = W / 2;

    // Select between the word and its half-swapped form
    always_comb begin
        if (cmd)
            dout = {din[W-HALF-1:0], din[W-1:W-HALF]};
        else
            dout = din;
    end
endmodule

// File: rtl/ks_var_rot.sv
// Module: ks_var_rot
// Variable left rotation by an AW-bit amount, built as a log-depth barrel
// with one conditional stage per amount bit. Assumes (1 << (AW-1)) < W.
// Purely combinational.
module ks_var_rot #(
    parameter int W  = 32,
    parameter int AW = 4
) (
    input  logic [W-1:0]  din,
    input  logic [AW-1:0] amt,
    output logic [W-1:0]  dout
);
    logic [W-1:0] stage [AW+1];

    assign stage[0] = din;

    // One stage per bit of the amount; stage gi rotates by 2**gi
    for (genvar gi = 0; gi < AW; gi++) begin : g_stage
        localparam int SH = (1 << gi) % W;
        localparam int RS = (W - SH) % W;
        assign stage[gi+1] = amt[gi] ? ((stage[gi] << SH) | (stage[gi] >> RS))
                                     : stage[gi];
    end

    assign dout = stage[AW];
endmodule

// File: rtl/ks_delay_line.sv
// Module: ks_delay_line
// Fixed-latency register chain with synchronous active-low clear.
// Output equals the input D cycles earlier. Assumes D >= 1.
module ks_delay_line #(
    parameter int W = 32,
    parameter int D = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] tap [D];

    // Shift the chain by one position each cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < D; i++) tap[i] <= '0;
        end else begin
            tap[0] <= din;
            for (int i = 1; i < D; i++) tap[i] <= tap[i-1];
        end
    end

    assign dout = tap[D-1];
endmodule

// File: rtl/rc5_ksched_step.sv
// Module: rc5_ksched_step
// One fully pipelined RC5-32 key-expansion mixing step.
//   A_new = ROTL(A + S + B', A_ROT)          -> a_out, 5 cycles after A
//   t     = A_new + B'
//   B_new = ROTL(t + L', t[ROT_W-1:0])       -> b_out, 6 cycles after A
//   b_cmd_out = t[ROT_W] (rotation by 2**ROT_W left to the consumer)
// Assumes B arrives one cycle after A/S and L three cycles after A/S,
// each with a command bit requesting a rotation by W/2 before use.
// S, raw L and raw L command are forwarded through fixed delay lines.
module rc5_ksched_step
    import ks_pkg::*;
#(
    parameter int W        = KS_WORD_W,
    parameter int ROT_W    = KS_ROT_W,
    parameter int A_ROT    = KS_A_ROT,
    parameter int S_DLY    = KS_S_DLY,
    parameter int L_DLY    = KS_L_DLY,
    parameter int LCMD_DLY = KS_LCMD_DLY
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] s_in,
    input  logic [W-1:0] b_in,
    input  logic         b_cmd_in,
    input  logic [W-1:0] l_in,
    input  logic         l_cmd_in,
    output logic [W-1:0] a_out,
    output logic [W-1:0] s_out,
    output logic [W-1:0] b_out,
    output logic         b_cmd_out,
    output logic [W-1:0] l_out,
    output logic         l_cmd_out
);
    localparam int CMD_BIT = ROT_W;   // first amount bit not applied here

    // Adjusted operands (combinational)
    logic [W-1:0] b_adj;
    logic [W-1:0] l_adj;
    logic [W-1:0] b_rot;

    // Pipeline registers, named by the cycle in which they become visible
    logic [W-1:0]     p1_as;    // A + S
    logic [W-1:0]     p2_asb;   // A + S + B'
    logic [W-1:0]     p2_b;     // B'
    logic [W-1:0]     p3_a;     // A_new
    logic [W-1:0]     p3_b;     // B'
    logic [W-1:0]     p4_t;     // t
    logic [W-1:0]     p4_a;     // A_new
    logic [W-1:0]     p4_l;     // L'
    logic [W-1:0]     p5_u;     // t + L'
    logic [ROT_W-1:0] p5_amt;   // applied rotation amount
    logic             p5_cmd;   // deferred rotation flag
    logic [W-1:0]     a_q;
    ks_word_cmd_t     b_q;

    ks_cmd_rot #(.W(W)) u_b_adj (.din(b_in), .cmd(b_cmd_in), .dout(b_adj));
    ks_cmd_rot #(.W(W)) u_l_adj (.din(l_in), .cmd(l_cmd_in), .dout(l_adj));

    ks_var_rot #(.W(W), .AW(ROT_W)) u_b_rot (
        .din (p5_u),
        .amt (p5_amt),
        .dout(b_rot)
    );

    // Stages 1-3: accumulate A + S + B' and apply the fixed A rotation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p1_as  <= '0;
            p2_asb <= '0;
            p2_b   <= '0;
            p3_a   <= '0;
            p3_b   <= '0;
        end else begin
            p1_as  <= a_in + s_in;
            p2_asb <= p1_as + b_adj;
            p2_b   <= b_adj;
            p3_a   <= {p2_asb[W-A_ROT-1:0], p2_asb[W-1:W-A_ROT]};
            p3_b   <= p2_b;
        end
    end

    // Stages 4-5: form t, bring in L', split the rotation amount
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p4_t   <= '0;
            p4_a   <= '0;
            p4_l   <= '0;
            p5_u   <= '0;
            p5_amt <= '0;
            p5_cmd <= 1'b0;
        end else begin
            p4_t   <= p3_a + p3_b;
            p4_a   <= p3_a;
            p4_l   <= l_adj;
            p5_u   <= p4_t + p4_l;
            p5_amt <= p4_t[ROT_W-1:0];
            p5_cmd <= p4_t[CMD_BIT];
        end
    end

    // Output registers for the A and B results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
        end else begin
            a_q      <= p4_a;
            b_q.word <= b_rot;
            b_q.cmd  <= p5_cmd;
        end
    end

    assign a_out     = a_q;
    assign b_out     = b_q.word;
    assign b_cmd_out = b_q.cmd;

    // Pass-through alignment lines for the next step in a chain
    ks_delay_line #(.W(W), .D(S_DLY)) u_s_dly (
        .clk(clk), .rst_n(rst_n), .din(s_in), .dout(s_out)
    );
    ks_delay_line #(.W(W), .D(L_DLY)) u_l_dly (
        .clk(clk), .rst_n(rst_n), .din(l_in), .dout(l_out)
    );
    ks_delay_line #(.W(1), .D(LCMD_DLY)) u_lcmd_dly (
        .clk(clk), .rst_n(rst_n), .din(l_cmd_in), .dout(l_cmd_out)
    );
endmodule

// File: rtl/rc5_ksched_step_chk.sv
// Module: rc5_ksched_step_chk
// Port-level properties of the key-expansion step, attached by bind.
// Keeps a cycles-since-reset counter so that no property looks back
// into cycles before reset was released.
module rc5_ksched_step_chk #(
    parameter int W        = 32,
    parameter int ROT_W    = 4,
    parameter int A_ROT    = 3,
    parameter int S_DLY    = 3,
    parameter int L_DLY    = 12,
    parameter int LCMD_DLY = 14
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] a_in,
    input logic [W-1:0] s_in,
    input logic [W-1:0] b_in,
    input logic         b_cmd_in,
    input logic [W-1:0] l_in,
    input logic         l_cmd_in,
    input logic [W-1:0] a_out,
    input logic [W-1:0] s_out,
    input logic [W-1:0] b_out,
    input logic         b_cmd_out,
    input logic [W-1:0] l_out,
    input logic         l_cmd_out
);
    localparam int CNT_MAX = 255;

    logic [7:0]   run_cnt;
    logic [W-1:0] s_hist [S_DLY];
    logic [W-1:0] l_hist [L_DLY];
    logic         lc_hist[LCMD_DLY];

    function automatic logic [W-1:0] rotl(input logic [W-1:0] x, input int n);
        logic [2*W-1:0] d;
        d = {x, x} << (n % W);
        return d[2*W-1:W];
    endfunction

    function automatic logic [W-1:0] half_adj(input logic [W-1:0] x, input logic c);
        return c ? rotl(x, W/2) : x;
    endfunction

    function automatic logic [W-1:0] b_expect(input logic [W-1:0] a_new,
                                              input logic [W-1:0] bp,
                                              input logic [W-1:0] lp);
        logic [W-1:0] t;
        t = a_new + bp;
        return rotl(t + lp, int'(t[ROT_W-1:0]));
    endfunction

    function automatic logic cmd_expect(input logic [W-1:0] a_new,
                                        input logic [W-1:0] bp);
        logic [W-1:0] t;
        t = a_new + bp;
        return t[ROT_W];
    endfunction

    // Count clean cycles since reset release
    always_ff @(posedge clk) begin
        if (!rst_n) run_cnt <= '0;
        else if (run_cnt != 8'(CNT_MAX)) run_cnt <= run_cnt + 8'd1;
    end

    // Reference history of the pass-through inputs
    always_ff @(posedge clk) begin
        s_hist[0]  <= s_in;
        l_hist[0]  <= l_in;
        lc_hist[0] <= l_cmd_in;
        for (int i = 1; i < S_DLY; i++)    s_hist[i]  <= s_hist[i-1];
        for (int i = 1; i < L_DLY; i++)    l_hist[i]  <= l_hist[i-1];
        for (int i = 1; i < LCMD_DLY; i++) lc_hist[i] <= lc_hist[i-1];
    end

    AST_A_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (run_cnt >= 8'd7) |->
        a_out == rotl($past(a_in, 5) + $past(s_in, 5)
                      + half_adj($past(b_in, 4), $past(b_cmd_in, 4)), A_ROT)); // R2

    AST_B_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (run_cnt >= 8'd8) |->
        b_out == b_expect($past(a_out, 1),
                          half_adj($past(b_in, 5), $past(b_cmd_in, 5)),
                          half_adj($past(l_in, 3), $past(l_cmd_in, 3)))); // R3

    AST_B_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (run_cnt >= 8'd8) |->
        b_cmd_out == cmd_expect($past(a_out, 1),
                                half_adj($past(b_in, 5), $past(b_cmd_in, 5)))); // R4

    AST_S_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (run_cnt >= 8'(S_DLY + 2)) |-> s_out == s_hist[S_DLY-1]); // R7

    AST_L_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (run_cnt >= 8'(L_DLY + 2)) |-> l_out == l_hist[L_DLY-1]); // R8

    AST_LCMD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (run_cnt >= 8'(LCMD_DLY + 2)) |-> l_cmd_out == lc_hist[LCMD_DLY-1]); // R8

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (a_out == '0 && b_out == '0 && s_out == '0 && l_out == '0
                    && !b_cmd_out && !l_cmd_out)); // R9
endmodule

bind rc5_ksched_step rc5_ksched_step_chk #(
    .W(W), .ROT_W(ROT_W), .A_ROT(A_ROT),
    .S_DLY(S_DLY), .L_DLY(L_DLY), .LCMD_DLY(LCMD_DLY)
) u_chk (.*);

// File: tb/sim_rc5_ksched_step.sv
// Bench for rc5_ksched_step: issues a table of steps back to back with the
// operand stagger of the interface, checks every output port against an
// independent model each cycle, then runs directed reset cases.
module sim_rc5_ksched_step;
    localparam int W     = 32;
    localparam int NVEC  = 16;
    localparam int EXTRA = 20;

    typedef struct packed {
        logic [31:0] a;
        logic [31:0] s;
        logic [31:0] b;
        logic [31:0] l;
        logic        bc;
        logic        lc;
    } vec_t;

    // Stimulus table; expected values come from the model functions below
    localparam vec_t TBL [NVEC] = '{
        '{32'h01234567, 32'h89abcdef, 32'h0f1e2d3c, 32'h4b5a6978, 1'b0, 1'b0},
        '{32'hffffffff, 32'hffffffff, 32'hffffffff, 32'hffffffff, 1'b1, 1'b1},
        '{32'h00000000, 32'h00000000, 32'h00000010, 32'h12345678, 1'b0, 1'b0},
        '{32'h00000000, 32'h00000000, 32'h00100000, 32'h12345678, 1'b1, 1'b0},
        '{32'h00000000, 32'h00000000, 32'h00000010, 32'h56781234, 1'b0, 1'b1},
        '{32'hb7e15163, 32'h00000000, 32'h00000000, 32'h00000000, 1'b0, 1'b0},
        '{32'h9e3779b9, 32'hb7e15163, 32'hdeadbeef, 32'h00000001, 1'b1, 1'b0},
        '{32'h80000000, 32'h80000000, 32'h00000000, 32'h80000000, 1'b0, 1'b1},
        '{32'h00000001, 32'h00000002, 32'h00000003, 32'h00000004, 1'b0, 1'b0},
        '{32'h13579bdf, 32'h2468ace0, 32'hfedcba98, 32'h76543210, 1'b1, 1'b1},
        '{32'h00000000, 32'h00000000, 32'h00000000, 32'h00000000, 1'b0, 1'b0},
        '{32'hcafef00d, 32'h0badc0de, 32'h55aa55aa, 32'haa55aa55, 1'b0, 1'b1},
        '{32'h7fffffff, 32'h00000001, 32'h00000000, 32'h00000000, 1'b0, 1'b0},
        '{32'h0000ffff, 32'hffff0000, 32'h12340000, 32'h00005678, 1'b1, 1'b1},
        '{32'h31415926, 32'h27182818, 32'h16180339, 32'h14142135, 1'b0, 1'b0},
        '{32'h5a5a5a5a, 32'ha5a5a5a5, 32'h3c3c3c3c, 32'hc3c3c3c3, 1'b1, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] a_in = '0, s_in = '0, b_in = '0, l_in = '0;
    logic        b_cmd_in = 1'b0, l_cmd_in = 1'b0;
    logic [31:0] a_out, s_out, b_out, l_out;
    logic        b_cmd_out, l_cmd_out;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    rc5_ksched_step u0 (
        .clk(clk), .rst_n(rst_n),
        .a_in(a_in), .s_in(s_in), .b_in(b_in), .b_cmd_in(b_cmd_in),
        .l_in(l_in), .l_cmd_in(l_cmd_in),
        .a_out(a_out), .s_out(s_out), .b_out(b_out), .b_cmd_out(b_cmd_out),
        .l_out(l_out), .l_cmd_out(l_cmd_out)
    );

    function automatic logic [31:0] m_rotl(input logic [31:0] x, input int n);
        logic [63:0] d;
        d = {x, x} << (n % 32);
        return d[63:32];
    endfunction

    function automatic logic [31:0] m_adj(input logic [31:0] x, input logic c);
        return c ? m_rotl(x, 16) : x;
    endfunction

    function automatic logic [31:0] m_a(input vec_t v);
        return m_rotl(v.a + v.s + m_adj(v.b, v.bc), 3);
    endfunction

    function automatic logic [31:0] m_t(input vec_t v);
        return m_a(v) + m_adj(v.b, v.bc);
    endfunction

    function automatic logic [31:0] m_b(input vec_t v);
        logic [31:0] t;
        t = m_t(v);
        return m_rotl(t + m_adj(v.l, v.lc), int'(t[3:0]));
    endfunction

    function automatic vec_t vec_at(input int j);
        if (j < 0 || j >= NVEC) return '0;
        return TBL[j];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all_zero(input string req);
        check(req, a_out, '0);
        check(req, b_out, '0);
        check(req, s_out, '0);
        check(req, l_out, '0);
        check(req, {31'd0, b_cmd_out}, '0);
        check(req, {31'd0, l_cmd_out}, '0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        // Reset state: outputs clear while reset is held (R9)
        repeat (3) @(negedge clk);
        check_all_zero("R9 reset state");
        rst_n = 1'b1;

        // Table walk: one step issued per cycle (R10); B one cycle and L
        // three cycles behind A/S (R6). Outputs sampled before driving.
        for (int k = 0; k < NVEC + EXTRA; k++) begin
            vec_t va, vb, vs, vl, vlc;
            string ta, tb;
            @(negedge clk);
            va  = vec_at(k - 5);
            vb  = vec_at(k - 6);
            vs  = vec_at(k - 3);
            vl  = vec_at(k - 15);
            vlc = vec_at(k - 17);
            ta = va.bc ? "R1 a_out" : "R2 a_out";
            tb = vb.lc ? "R5 b_out" : "R3 b_out";
            check(ta, a_out, m_a(va));
            check(tb, b_out, m_b(vb));
            check("R4 b_cmd_out", {31'd0, b_cmd_out}, {31'd0, m_t(vb)[4]});
            check("R7 s_out", s_out, vs.s);
            check("R8 l_out", l_out, vl.l);
            check("R8 l_cmd_out", {31'd0, l_cmd_out}, {31'd0, vlc.lc});
            a_in     = vec_at(k).a;
            s_in     = vec_at(k).s;
            b_in     = vec_at(k - 1).b;
            b_cmd_in = vec_at(k - 1).bc;
            l_in     = vec_at(k - 3).l;
            l_cmd_in = vec_at(k - 3).lc;
        end

        // Directed: step 2 has t[3:0]=0 and t[4]=1; step 3 is the same step
        // with B pre-swapped and its command set, giving the same result (R1)
        check("R1 swapped B matches", m_b(TBL[3]), m_b(TBL[2]));
        check("R4 t bit4 set", {31'd0, m_t(TBL[2])[4]}, 32'd1);

        // Directed: reset while the pipeline holds live steps (R9, R10)
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            a_in = TBL[k].a; s_in = TBL[k].s;
            b_in = TBL[k].b; b_cmd_in = TBL[k].bc;
            l_in = TBL[k].l; l_cmd_in = 1'b1;
        end
        rst_n = 1'b0;
        @(negedge clk);
        check_all_zero("R9 reset mid-flight");
        @(negedge clk);
        check_all_zero("R9 reset held with live inputs");
        a_in = '0; s_in = '0; b_in = '0; l_in = '0;
        b_cmd_in = 1'b0; l_cmd_in = 1'b0;
        rst_n = 1'b1;
        for (int k = 0; k < 18; k++) begin
            @(negedge clk);
            check_all_zero("R10 no stale step after reset");
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule